// File: doc/BRIEF.md
# Machine-Cycle Sequencer

This block paces one instruction of an 8-bit processor core through its machine cycles. One clock of the block stands for one edge of the emulated processor clock. A phase bit separates the rising half of each T-state from the falling half. The block always opens an instruction with an opcode fetch cycle. In the rising half of T3 of that fetch it samples the opcode byte from the data bus and looks it up in a table. The table returns a list of machine-cycle lengths in T-states, and from then on each cycle boundary falls where the list says.

An index prefix byte is handled inside the same instruction. The prefix takes the first machine cycle. The following opcode is fetched in the second machine cycle and looked up in a separate prefixed table. That table's length list covers the whole instruction, including the prefix fetch. Downstream bus and datapath logic read the current machine-cycle index, T-state number and phase. They start the next opcode fetch after the one-half-tick end-of-instruction pulse.

Top module: `mcSequencer`

## Requirements
- R1: While `rst` is high and on the first half-tick after it falls, the outputs read machine cycle 1, T-state 1, phase 0 and `instrDone` 0. Any prefix latched before the reset is dropped.
- R2: `phase` alternates on every clock. Within a machine cycle, `tState` holds through phase 0 and advances by one after phase 1, counting up from 1.
- R3: `opByte` is sampled only on the phase-0 half-tick of T3 of a fetch cycle. A fetch cycle is machine cycle 1, or machine cycle 2 when a prefix is latched. At every other time the value on `opByte` has no effect on the cycle lengths.
- R4: Each machine cycle lasts exactly the number of T-states held in its slot of the decoded length list, which is twice that many clocks. `tState` restarts at 1 in every new machine cycle, and every length is at least 3.
- R5: An instruction ends after its last nonzero slot, or after slot 6, which is the maximum. `instrDone` is high for one clock, on the phase-1 half-tick of the final T-state of the final machine cycle. The next clock shows machine cycle 1, T-state 1.
- R6: Fetching byte FD hex in machine cycle 1 latches the prefix. It raises no `instrDone` at the end of that cycle and continues into machine cycle 2, where the next byte is decoded with the prefixed table. FD followed by 39 hex takes lengths 4,4,4,3, while 39 hex alone takes 4,4,3.
- R7: An opcode absent from the main table runs as a single 4-T-state cycle. A byte absent from the prefixed table, FD included, gives lengths 4,4.
- R8: The main table gives these lengths: 00 → 4; 01 → 4,3,3; 03 → 6; 09 → 4,4,3; 39 → 4,4,3; CD → 4,3,4,3,3; E3 → 4,3,4,3,5. The prefixed table gives these: 09 → 4,4,4,3; 39 → 4,4,4,3; 21 → 4,4,3,3; 34 → 4,4,3,5,4,3; E3 → 4,4,3,4,3,5 (all hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | One rising edge per emulated clock edge (half-tick) |
| rst | input | 1 | Active-high synchronous reset |
| opByte | input | 8 | Data-bus byte, sampled at fetch T3 phase 0 |
| mCycle | output | 3 | Current machine-cycle index, 1 to 6 |
| tState | output | 3 | Current T-state within the machine cycle, from 1 |
| phase | output | 1 | 0 on the rising half of a T-state, 1 on the falling half |
| instrDone | output | 1 | High on the last half-tick of the instruction |

## Verification
The assertions assume that every table length is at least 3. Under that assumption a decode at T3 can never leave the counter beyond the new cycle length. They also assume that reset is the only thing that interrupts an instruction. The stimulus keeps a filler byte (CD hex, which has a distinct length list) on the opcode input at all times except the single sampling half-tick of each fetch. A sample taken at any other moment would therefore show up as a wrong length list. Reset is applied mid-instruction only once, during the second cycle of a prefixed instruction, and the bench expects nothing from that aborted instruction.

// File: rtl/mcSeqPkg.sv
package mcSeqPkg;
  parameter int MaxCycles = 6;
  parameter int LenW = 3;
  parameter int TW = 3;
  parameter int MW = 3;
  parameter int OpW = 8;

  localparam logic [OpW-1:0] IndexPrefix = 8'hFD;

  typedef logic [LenW-1:0] len_t;
  typedef len_t [MaxCycles-1:0] lenList_t;

  typedef struct packed {
    logic decode;
    logic stepT;
    logic endCycle;
    logic endInstr;
  } strobe_t;

  typedef struct packed {
    logic fetchT3;
    logic atLastT;
    logic lastSlot;
  } status_t;

  // Slot 0 is the first machine cycle; a zero closes the list.
  function automatic lenList_t mkList(input int a, input int b, input int c,
                                      input int d, input int e, input int f);
    lenList_t l;
    l[0] = len_t'(a);
    l[1] = len_t'(b);
    l[2] = len_t'(c);
    l[3] = len_t'(d);
    l[4] = len_t'(e);
    l[5] = len_t'(f);
    return l;
  endfunction

  function automatic lenList_t mainEntry(input logic [OpW-1:0] op);
    case (op)
      8'h00:   return mkList(4, 0, 0, 0, 0, 0);
      8'h01:   return mkList(4, 3, 3, 0, 0, 0);
      8'h03:   return mkList(6, 0, 0, 0, 0, 0);
      8'h09:   return mkList(4, 4, 3, 0, 0, 0);
      8'h39:   return mkList(4, 4, 3, 0, 0, 0);
      8'hCD:   return mkList(4, 3, 4, 3, 3, 0);
      8'hE3:   return mkList(4, 3, 4, 3, 5, 0);
      default: return mkList(4, 0, 0, 0, 0, 0);
    endcase
  endfunction

  // Lists cover the prefix fetch as slot 0.
  function automatic lenList_t prefEntry(input logic [OpW-1:0] op);
    case (op)
      8'h09:   return mkList(4, 4, 4, 3, 0, 0);
      8'h39:   return mkList(4, 4, 4, 3, 0, 0);
      8'h21:   return mkList(4, 4, 3, 3, 0, 0);
      8'h34:   return mkList(4, 4, 3, 5, 4, 3);
      8'hE3:   return mkList(4, 4, 3, 4, 3, 5);
      default: return mkList(4, 4, 0, 0, 0, 0);
    endcase
  endfunction
endpackage

// File: rtl/mcSeqCtrl.sv
module mcSeqCtrl
  import mcSeqPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  status_t stat,
  output strobe_t strb,
  output logic    phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  always_comb begin
    strb.decode   = !phase && stat.fetchT3;
    strb.stepT    = phase && !stat.atLastT;
    strb.endCycle = phase && stat.atLastT;
    strb.endInstr = phase && stat.atLastT && stat.lastSlot;
  end

  // R2: half-tick phase alternates every clock
  p_phase_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase != $past(phase)));
endmodule

// File: rtl/mcSeqDatapath.sv
module mcSeqDatapath
  import mcSeqPkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OpW-1:0] opByte,
  input  strobe_t        strb,
  output status_t        stat,
  output logic [MW-1:0]  mCycle,
  output logic [TW-1:0]  tState
);
  localparam lenList_t FetchList  = mkList(4, 0, 0, 0, 0, 0);
  localparam lenList_t PrefixList = mkList(4, 4, 0, 0, 0, 0);

  lenList_t      lens;
  logic          prefixed;
  len_t          curLen;
  len_t          nextLen;
  logic [MW-1:0] fetchM;

  always_comb begin
    curLen  = '0;
    nextLen = '0;
    for (int i = 0; i < MaxCycles; i++) begin
      if (int'(mCycle) == i + 1) curLen  = lens[i];
      if (int'(mCycle) == i)     nextLen = lens[i];
    end
  end

  always_comb begin
    fetchM        = prefixed ? MW'(2) : MW'(1);
    stat.fetchT3  = (mCycle == fetchM) && (tState == TW'(3));
    stat.atLastT  = (tState == TW'(curLen));
    stat.lastSlot = (nextLen == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mCycle   <= MW'(1);
      tState   <= TW'(1);
      lens     <= FetchList;
      prefixed <= 1'b0;
    end else begin
      if (strb.decode) begin
        if (!prefixed && opByte == IndexPrefix) begin
          lens     <= PrefixList;
          prefixed <= 1'b1;
        end else if (prefixed) begin
          lens <= prefEntry(opByte);
        end else begin
          lens <= mainEntry(opByte);
        end
      end
      if (strb.endInstr) begin
        mCycle   <= MW'(1);
        tState   <= TW'(1);
        lens     <= FetchList;
        prefixed <= 1'b0;
      end else if (strb.endCycle) begin
        mCycle <= mCycle + MW'(1);
        tState <= TW'(1);
      end else if (strb.stepT) begin
        tState <= tState + TW'(1);
      end
    end
  end

  // R4: a new machine cycle opens at T1
  p_tstate_restart_r4: assert property (@(posedge clk) disable iff (rst)
    strb.endCycle |=> (tState == TW'(1)));
  // R4: no machine cycle shorter than three T-states
  p_len_floor_r4: assert property (@(posedge clk) disable iff (rst)
    strb.endCycle |-> (tState >= TW'(3)));
  // R2: T-state steps by one after the falling half
  p_tstep_r2: assert property (@(posedge clk) disable iff (rst)
    strb.stepT |=> (tState == $past(tState) + TW'(1)));
  // R2: counters hold through the rising half
  p_hold_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (!strb.stepT && !strb.endCycle) |=> ($stable(tState) && $stable(mCycle)));
  // R5: finished instruction returns to M1/T1
  p_done_to_m1_r5: assert property (@(posedge clk) disable iff (rst)
    strb.endInstr |=> (mCycle == MW'(1) && tState == TW'(1)));
  // R5: index stays within the six-cycle limit
  p_mcycle_range_r5: assert property (@(posedge clk) disable iff (rst)
    (mCycle >= MW'(1)) && (int'(mCycle) <= MaxCycles));
  // R6: the prefix cycle never ends the instruction
  p_prefix_continue_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.endCycle && prefixed && mCycle == MW'(1)) |-> !strb.endInstr);
endmodule

// File: rtl/mcSequencer.sv
module mcSequencer
  import mcSeqPkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OpW-1:0] opByte,
  output logic [MW-1:0]  mCycle,
  output logic [TW-1:0]  tState,
  output logic           phase,
  output logic           instrDone
);
  strobe_t strb;
  status_t stat;

  mcSeqCtrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .stat  (stat),
    .strb  (strb),
    .phase (phase)
  );

  mcSeqDatapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .opByte (opByte),
    .strb   (strb),
    .stat   (stat),
    .mCycle (mCycle),
    .tState (tState)
  );

  assign instrDone = strb.endInstr;
endmodule

// File: tb/tb_mcSequencer.sv
`timescale 1ns/1ps
module tb_mcSequencer;
  import mcSeqPkg::*;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [OpW-1:0] opByte;
  logic [MW-1:0]  mCycle;
  logic [TW-1:0]  tState;
  logic           phase;
  logic           instrDone;

  localparam logic [OpW-1:0] Junk = 8'hCD;

  typedef struct {
    lenList_t lens;
    string    tag;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  int   halfCnt[MaxCycles+1];
  bit   expectStart = 0;

  mcSequencer dut (
    .clk(clk), .rst(rst), .opByte(opByte),
    .mCycle(mCycle), .tState(tState), .phase(phase), .instrDone(instrDone)
  );

  always #2.5 clk = ~clk;

  // Monitor: measures every machine cycle and compares at each instrDone
  always @(negedge clk) begin
    int m;
    lenList_t got;
    exp_t e;
    m = int'(mCycle);
    if (rst) begin
      for (int i = 0; i <= MaxCycles; i++) halfCnt[i] = 0;
      expectStart = 0;
    end else if (m < 1 || m > MaxCycles) begin
      checks++; errors++;
      $display("FAIL R5 mCycle out of range: actual %0d expected 1..%0d", m, MaxCycles);
    end else begin
      if (expectStart) begin
        checks++;
        if (m != 1) begin
          errors++;
          $display("FAIL R5 after instrDone: actual M%0d expected M1", m);
        end
        expectStart = 0;
      end
      checks++;
      if (phase !== halfCnt[m][0] || tState !== TW'(halfCnt[m] / 2 + 1)) begin
        errors++;
        $display("FAIL R2 M%0d: actual T%0d phase %0d expected T%0d phase %0d",
                 m, tState, phase, halfCnt[m] / 2 + 1, halfCnt[m][0]);
      end
      halfCnt[m]++;
      if (instrDone) begin
        checks++;
        if (phase !== 1'b1) begin
          errors++;
          $display("FAIL R5 instrDone on phase: actual %0d expected 1", phase);
        end
        got = '0;
        for (int i = 1; i <= MaxCycles; i++) got[i-1] = len_t'(halfCnt[i] / 2);
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R5 unexpected instrDone: actual lens %h expected none", got);
        end else begin
          e = expQ.pop_front();
          if (got !== e.lens) begin
            errors++;
            $display("FAIL %s: actual lens %h expected %h", e.tag, got, e.lens);
          end
        end
        for (int i = 0; i <= MaxCycles; i++) halfCnt[i] = 0;
        expectStart = 1;
      end
    end
  end

  task automatic waitFetch(input int m);
    do @(negedge clk); while (!(int'(mCycle) == m && tState == TW'(3) && phase == 1'b0));
  endtask

  // Driver: pushes the expected list, presents bytes only at the sampling half-tick (R3)
  task automatic runInstr(input bit pre, input logic [OpW-1:0] op,
                          input lenList_t lens, input string tag);
    exp_t e;
    e.lens = lens;
    e.tag  = tag;
    expQ.push_back(e);
    waitFetch(1);
    if (pre) begin
      opByte = IndexPrefix;
      @(negedge clk);
      opByte = Junk;
      waitFetch(2);
    end
    opByte = op;
    @(negedge clk);
    opByte = Junk;
    do @(negedge clk); while (!instrDone);
  endtask

  task automatic checkReset(input string tag);
    checks++;
    if (mCycle !== MW'(1) || tState !== TW'(1) || phase !== 1'b0 || instrDone !== 1'b0) begin
      errors++;
      $display("FAIL %s: actual M%0d T%0d ph%0d done%0d expected M1 T1 ph0 done0",
               tag, mCycle, tState, phase, instrDone);
    end
  endtask

  initial begin
    opByte = Junk;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checkReset("R1 reset state");
    rst = 1'b0;

    runInstr(0, 8'h00, mkList(4, 0, 0, 0, 0, 0), "R4 R8 op 00");
    runInstr(0, 8'h01, mkList(4, 3, 3, 0, 0, 0), "R3 R4 R8 op 01");
    runInstr(0, 8'h03, mkList(6, 0, 0, 0, 0, 0), "R4 R8 op 03");
    runInstr(0, 8'h09, mkList(4, 4, 3, 0, 0, 0), "R8 op 09");
    runInstr(0, 8'hCD, mkList(4, 3, 4, 3, 3, 0), "R8 op CD");
    runInstr(0, 8'hE3, mkList(4, 3, 4, 3, 5, 0), "R5 R8 op E3");
    runInstr(0, 8'h47, mkList(4, 0, 0, 0, 0, 0), "R7 main miss 47");
    runInstr(0, 8'h39, mkList(4, 4, 3, 0, 0, 0), "R6 unprefixed 39");
    runInstr(1, 8'h39, mkList(4, 4, 4, 3, 0, 0), "R6 prefixed FD 39");
    runInstr(1, 8'h34, mkList(4, 4, 3, 5, 4, 3), "R5 R8 six cycles FD 34");
    runInstr(1, 8'h21, mkList(4, 4, 3, 3, 0, 0), "R8 FD 21");
    runInstr(1, 8'hE3, mkList(4, 4, 3, 4, 3, 5), "R8 FD E3");
    runInstr(1, 8'h09, mkList(4, 4, 4, 3, 0, 0), "R8 FD 09");
    runInstr(1, 8'h47, mkList(4, 4, 0, 0, 0, 0), "R7 prefixed miss FD 47");
    runInstr(1, IndexPrefix, mkList(4, 4, 0, 0, 0, 0), "R7 double prefix FD FD");
    runInstr(0, 8'h00, mkList(4, 0, 0, 0, 0, 0), "R6 prefix cleared after instr");

    // Reset inside the second cycle of a prefixed instruction
    waitFetch(1);
    opByte = IndexPrefix;
    @(negedge clk);
    opByte = Junk;
    do @(negedge clk); while (mCycle != MW'(2));
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checkReset("R1 reset mid instruction");
    rst = 1'b0;
    runInstr(0, 8'h39, mkList(4, 4, 3, 0, 0, 0), "R1 prefix dropped by reset");

    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R5 pending instructions: actual %0d expected 0", expQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R5 watchdog: actual timeout expected instrDone");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule